// File: doc/BRIEF.md
# Debug Interrupt Status Register

This block is a 16-bit control and status word for an on-chip debug unit. It records three debug interrupt causes in sticky flags: a hit from the bus-breakpoint comparator, a hit from the program-breakpoint comparator, and a high-to-low transition on an external, asynchronous debug request pin. Software reads the word to find out which cause raised the interrupt. It then clears each flag by writing a 1 to that flag's bit. The same word holds a plain read/write bit that moves the unit from normal mode into emulation mode.

The register port is a simple synchronous strobe interface. A write takes effect on the rising clock edge where `csr_wr_en` is high. Read data is combinational and is valid in the same cycle as `csr_rd_en`. No data stream crosses this block, so it has no valid/ready handshake and never applies back-pressure. The strobes are always accepted in the cycle they are presented.

The comparator strobes are single-cycle pulses in the clock domain. The external pin passes through a two-flop synchronizer before its falling edge is detected. Field layout: bit 3 is the mode bit, bit 2 is the bus-breakpoint flag, bit 1 is the program-breakpoint flag, bit 0 is the pin flag, and bits 15 to 4 are reserved.

Top module: `dbg_irq_status`

## Requirements
- R1: While reset is asserted and after it is released, the word reads 0x0000, `emu_mode` is 0 and `dbg_irq` is 0.
- R2: Bits 15 to 4 always read 0, whatever value is written to them.
- R3: Bit 3 is read/write. A write loads it from `csr_wr_data[3]`, it reads back as written, and `emu_mode` follows it (0 = normal mode, 1 = emulation mode).
- R4: A high cycle on `bus_brk_hit` sets bit 2 at the next clock edge. The bit then stays set until software clears it.
- R5: A high cycle on `prog_brk_hit` sets bit 1 at the next clock edge. The bit then stays set until software clears it.
- R6: A 1-to-0 change on `ext_dbg_req_n` sets bit 0 on the third rising edge after the change. Holding the pin low gives no further event, and a 0-to-1 change sets nothing.
- R7: Writing 1 to bit 2, 1 or 0 clears that flag. Writing 0 leaves it unchanged. A write never sets a flag.
- R8: When a source event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: `dbg_irq` is the OR of bits 2, 1 and 0. It stays high until every set flag has been cleared.
- R10: `csr_rd_data` shows the current word in the same cycle `csr_rd_en` is high, and reads 0 otherwise. Reads never change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the word |
| csr_wr_en | input | 1 | Write strobe |
| csr_wr_data | input | 16 | Write data |
| csr_rd_en | input | 1 | Read strobe |
| csr_rd_data | output | 16 | Read data, valid while csr_rd_en is high |
| bus_brk_hit | input | 1 | Bus-breakpoint event pulse |
| prog_brk_hit | input | 1 | Program-breakpoint event pulse |
| ext_dbg_req_n | input | 1 | Asynchronous external debug request pin, falling edge is the event |
| emu_mode | output | 1 | Emulation mode enable (bit 3) |
| dbg_irq | output | 1 | Combined debug interrupt |

## Verification
Several behaviours are checked by the assertions on every cycle:
- each comparator pulse sets its flag on the next edge, and a simultaneous clear does not undo it;
- a write of 1 clears a flag that has no competing event;
- a write of 0 keeps a flag;
- no flag rises without a cause;
- the mode bit loads from the write data;
- reserved bits read as zero;
- the interrupt output agrees with the read flags.

Other behaviours only the bench scenarios can show. These are the exact three-edge latency of the pin path, the absence of repeat events while the pin is held low or goes high, the stickiness of a flag across idle cycles, and the return to an idle interrupt once every flag is cleared in turn.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;
  localparam int WORD_W  = 16;
  localparam int NUM_EVT = 3;
  localparam int SYNC_STAGES = 2;
  // bit positions software decodes
  localparam int BIT_PIN  = 0;
  localparam int BIT_PROG = 1;
  localparam int BIT_BUS  = 2;
  localparam int BIT_MODE = 3;
  localparam int RSVD_LO  = BIT_MODE + 1;
endpackage

// File: rtl/dbg_pin_fall_detect.sv
module dbg_pin_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic fall_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // synchronizer chain, idles high like the pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], pin_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sync_q[STAGES-1];
  end

  assign fall_pulse = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dbg_sticky_flag.sv
module dbg_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dbg_irq_status.sv
module dbg_irq_status
  import dbg_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_en,
  input  logic [WORD_W-1:0] csr_wr_data,
  input  logic              csr_rd_en,
  output logic [WORD_W-1:0] csr_rd_data,
  input  logic              bus_brk_hit,
  input  logic              prog_brk_hit,
  input  logic              ext_dbg_req_n,
  output logic              emu_mode,
  output logic              dbg_irq
);
  localparam int RSVD_W = WORD_W - RSVD_LO;

  logic               pin_fall;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] evt_clr;
  logic [NUM_EVT-1:0] flags;
  logic               mode_q;
  logic               unused_rsvd;

  dbg_pin_fall_detect #(.STAGES(SYNC_STAGES)) u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_async  (ext_dbg_req_n),
    .fall_pulse (pin_fall)
  );

  always_comb begin
    evt_set           = '0;
    evt_set[BIT_PIN]  = pin_fall;
    evt_set[BIT_PROG] = prog_brk_hit;
    evt_set[BIT_BUS]  = bus_brk_hit;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    assign evt_clr[i] = csr_wr_en & csr_wr_data[i];
    dbg_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_set[i]),
      .clr_i  (evt_clr[i]),
      .flag_o (flags[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= 1'b0;
    else if (csr_wr_en) mode_q <= csr_wr_data[BIT_MODE];
  end

  assign unused_rsvd = ^csr_wr_data[WORD_W-1:RSVD_LO];

  always_comb begin
    csr_rd_data = '0;
    if (csr_rd_en) csr_rd_data = {{RSVD_W{1'b0}}, mode_q, flags};
  end

  assign emu_mode = mode_q;
  assign dbg_irq  = |flags;
endmodule

// File: rtl/dbg_irq_status_chk.sv
module dbg_irq_status_chk
  import dbg_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              csr_wr_en,
  input logic [WORD_W-1:0] csr_wr_data,
  input logic              csr_rd_en,
  input logic [WORD_W-1:0] csr_rd_data,
  input logic              bus_brk_hit,
  input logic              prog_brk_hit,
  input logic              emu_mode,
  input logic              dbg_irq,
  input logic [NUM_EVT-1:0] flags
);
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_data[WORD_W-1:RSVD_LO] == '0);

  a_r3_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |=> emu_mode == $past(csr_wr_data[BIT_MODE]));

  a_r4_bus_set: assert property (@(posedge clk) disable iff (!rst_n)
    bus_brk_hit |=> flags[BIT_BUS]);

  a_r5_prog_set: assert property (@(posedge clk) disable iff (!rst_n)
    prog_brk_hit |=> flags[BIT_PROG]);

  a_r7_clear_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_en && csr_wr_data[BIT_BUS] && !bus_brk_hit) |=> !flags[BIT_BUS]);

  a_r7_keep_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[BIT_BUS] && !(csr_wr_en && csr_wr_data[BIT_BUS])) |=> flags[BIT_BUS]);

  a_r7_no_spurious_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[BIT_BUS]) |-> $past(bus_brk_hit));

  a_r7_no_spurious_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[BIT_PROG]) |-> $past(prog_brk_hit));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_brk_hit && csr_wr_en && csr_wr_data[BIT_BUS]) |=> flags[BIT_BUS]);

  a_r9_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_en |-> (dbg_irq == |csr_rd_data[NUM_EVT-1:0]));
endmodule

bind dbg_irq_status dbg_irq_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_wr_en    (csr_wr_en),
  .csr_wr_data  (csr_wr_data),
  .csr_rd_en    (csr_rd_en),
  .csr_rd_data  (csr_rd_data),
  .bus_brk_hit  (bus_brk_hit),
  .prog_brk_hit (prog_brk_hit),
  .emu_mode     (emu_mode),
  .dbg_irq      (dbg_irq),
  .flags        (flags)
);

// File: tb/dbg_irq_status_bench.sv
module dbg_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [15:0] csr_wr_data = '0;
  logic        csr_rd_en = 1'b0;
  logic [15:0] csr_rd_data;
  logic        bus_brk_hit = 1'b0;
  logic        prog_brk_hit = 1'b0;
  logic        ext_dbg_req_n = 1'b1;
  logic        emu_mode;
  logic        dbg_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  dbg_irq_status u_dbg_irq_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_wr_en     (csr_wr_en),
    .csr_wr_data   (csr_wr_data),
    .csr_rd_en     (csr_rd_en),
    .csr_rd_data   (csr_rd_data),
    .bus_brk_hit   (bus_brk_hit),
    .prog_brk_hit  (prog_brk_hit),
    .ext_dbg_req_n (ext_dbg_req_n),
    .emu_mode      (emu_mode),
    .dbg_irq       (dbg_irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // read at the falling edge, data is combinational
  task automatic rd(output logic [15:0] v);
    csr_rd_en = 1'b1;
    #1 v = csr_rd_data;
    csr_rd_en = 1'b0;
  endtask

  task automatic wr(logic [15:0] d);
    csr_wr_en = 1'b1; csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 1'b0; csr_wr_data = '0;
  endtask

  task automatic pulse_bus();
    bus_brk_hit = 1'b1; @(negedge clk); bus_brk_hit = 1'b0;
  endtask

  task automatic pulse_prog();
    prog_brk_hit = 1'b1; @(negedge clk); prog_brk_hit = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(v);
    check("R1 word", v, 16'h0000);
    check("R1 emu_mode", {15'd0, emu_mode}, 16'd0);
    check("R1 irq", {15'd0, dbg_irq}, 16'd0);
  endtask

  task automatic t_mode_reserved();
    logic [15:0] v;
    wr(16'hFFF8);
    rd(v);
    check("R2 R3 reserved masked, mode set", v, 16'h0008);
    check("R3 emu_mode high", {15'd0, emu_mode}, 16'd1);
    check("R7 write never sets flags irq", {15'd0, dbg_irq}, 16'd0);
    wr(16'h0000);
    rd(v);
    check("R3 mode cleared", v, 16'h0000);
    check("R3 emu_mode low", {15'd0, emu_mode}, 16'd0);
  endtask

  task automatic t_bus();
    logic [15:0] v;
    pulse_bus();
    rd(v);
    check("R4 bus flag set", v, 16'h0004);
    check("R9 irq from bus", {15'd0, dbg_irq}, 16'd1);
    repeat (5) @(negedge clk);
    rd(v);
    check("R4 bus flag sticky", v, 16'h0004);
    wr(16'h0003);
    rd(v);
    check("R7 write 0 keeps bus flag", v, 16'h0004);
    wr(16'h0004);
    rd(v);
    check("R7 write 1 clears bus flag", v, 16'h0000);
    check("R9 irq low after clear", {15'd0, dbg_irq}, 16'd0);
  endtask

  task automatic t_prog();
    logic [15:0] v;
    pulse_prog();
    rd(v);
    check("R5 prog flag set", v, 16'h0002);
    wr(16'h0005);
    rd(v);
    check("R7 write 0 keeps prog flag", v, 16'h0002);
    wr(16'h0002);
    rd(v);
    check("R7 write 1 clears prog flag", v, 16'h0000);
  endtask

  task automatic t_pin();
    logic [15:0] v;
    ext_dbg_req_n = 1'b0;
    repeat (2) @(negedge clk);
    rd(v);
    check("R6 pin flag not before third edge", v, 16'h0000);
    @(negedge clk);
    rd(v);
    check("R6 pin flag at third edge", v, 16'h0001);
    wr(16'h0001);
    repeat (10) @(negedge clk);
    rd(v);
    check("R6 held low gives no new event", v, 16'h0000);
    ext_dbg_req_n = 1'b1;
    repeat (6) @(negedge clk);
    rd(v);
    check("R6 rising edge gives no event", v, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    pulse_bus();
    bus_brk_hit = 1'b1;
    wr(16'h0004);
    bus_brk_hit = 1'b0;
    rd(v);
    check("R8 set wins over clear", v, 16'h0004);
    wr(16'h0004);
    rd(v);
    check("R7 clear after collision", v, 16'h0000);
  endtask

  task automatic t_multi();
    logic [15:0] v;
    pulse_bus();
    pulse_prog();
    ext_dbg_req_n = 1'b0;
    repeat (4) @(negedge clk);
    ext_dbg_req_n = 1'b1;
    rd(v);
    check("R4 R5 R6 all flags", v, 16'h0007);
    wr(16'h0004);
    rd(v);
    check("R7 selective clear", v, 16'h0003);
    check("R9 irq held by remaining", {15'd0, dbg_irq}, 16'd1);
    wr(16'h0002);
    check("R9 irq held by pin flag", {15'd0, dbg_irq}, 16'd1);
    wr(16'h0001);
    check("R9 irq low when all clear", {15'd0, dbg_irq}, 16'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_read();
    logic [15:0] v;
    pulse_prog();
    #1 check("R10 no strobe reads zero", csr_rd_data, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      rd(v);
      @(negedge clk);
    end
    rd(v);
    check("R10 reads have no side effect", v, 16'h0002);
    wr(16'h0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 read during reset", csr_rd_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_reserved();
    t_bus();
    t_prog();
    t_pin();
    t_collision();
    t_multi();
    t_read();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule